// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block connects a synchronous host request port to an asynchronous byte-wide static RAM. The RAM has a 21-bit address space and active-low chip select, write enable and output enable strobes. The host presents a request through a valid/ready handshake. A request carries a write flag, an address and write data. A read returns its byte together with a one-cycle valid pulse.

The strobe sequence is built from the RAM's nanosecond timing figures for a speed grade chosen by parameter (70, 85, 100 or 120 ns). Each figure is turned into a clock-cycle count by rounding up, with a minimum of one cycle.

A read lowers chip select and output enable together for the access time, then captures the data bus. It then waits for the RAM's output to turn off before the next request is taken. A write keeps output enable high throughout and lowers chip select and write enable for the write pulse. It then raises both strobes for a recovery period, so that the address only ever changes while the strobes are high.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, all three strobes are high (1), the data driver enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for exactly N_ACC cycles, counted from the edge that accepts the request. N_ACC = ceil(max(tAA, tOE) / clock period); for the 70 ns grade at 5 ns this is 14.
- R3: After a read, `rsp_valid` is high for exactly one cycle, starting at the edge N_ACC cycles after acceptance. `rsp_rdata` carries the byte the RAM drove on `mem_din` at that edge.
- R4: A write holds `mem_cs_n` and `mem_we_n` low for exactly N_WP = ceil(max(tWP, tDW) / period) cycles (10 at the default settings), with `mem_oe_n` high and `mem_dout` equal to the request's write data.
- R5: After the write pulse, the write waits N_REC = max(ceil(tWR/period), ceil(tWC/period) - N_WP) cycles with the strobes high. `req_ready` rises N_WP + N_REC cycles (14) after acceptance.
- R6: `mem_addr` never changes while `mem_cs_n` and `mem_we_n` are both low. It changes only on a cycle where the controller accepts a request.
- R7: `mem_dout_en` is high only while `mem_oe_n` is high. It is high from the start of the write pulse until the end of recovery (N_WP + N_REC cycles).
- R8: After a read, `req_ready` stays low for N_OFF = max(ceil(tOHZ/period), ceil(tRC/period) - N_ACC) further cycles (5 at the default settings). A request offered while `req_ready` is low has no effect on the RAM address or contents.
- R9: A byte written to an address is returned by a later read of that address, including at address 0 and at address 0x1FFFFF. Other addresses keep their contents.
- R10: While `req_ready` is high, no strobe is low and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Request byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 21 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dout | output | 8 | Data toward the RAM |
| mem_dout_en | output | 1 | Enable for the external tristate driver of `mem_dout` |
| mem_din | input | 8 | Data from the RAM |

## Verification
All results are timed from the accepting edge E0, the first rising edge at which valid and ready are both high.

- **Read:** the strobes are low after edges E0 to E13. Read data and `rsp_valid` appear after E14, and `req_ready` returns after E19.
- **Write:** write enable is low after E0 to E9, the driver stays on through E13, and `req_ready` returns after E14.

The bench drives inputs and samples outputs on falling edges. It indexes each sample by the number of rising edges since E0 and compares it with the window that it computes itself from the rounded timing figures. Its RAM model commits and presents data on falling edges, so the capture edge always sees settled data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_GAP,
    ST_WR,
    ST_WR_REC
  } ctl_state_e;

  // Timing figures of one speed grade, in picoseconds.
  typedef struct packed {
    int unsigned t_rc;
    int unsigned t_aa;
    int unsigned t_oe;
    int unsigned t_ohz;
    int unsigned t_wc;
    int unsigned t_wp;
    int unsigned t_dw;
    int unsigned t_wr;
  } grade_t;

  function automatic grade_t grade_timing(input int unsigned grade_ns);
    grade_t g;
    case (grade_ns)
      85:      g = '{85000, 85000, 45000, 30000, 85000, 60000, 35000, 5000};
      100:     g = '{100000, 100000, 50000, 35000, 100000, 70000, 40000, 5000};
      120:     g = '{120000, 120000, 55000, 40000, 120000, 80000, 45000, 5000};
      default: g = '{70000, 70000, 40000, 25000, 70000, 50000, 30000, 5000};
    endcase
    return g;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Round a duration up to whole clock cycles, never fewer than one.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned sat_diff(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  function automatic int unsigned cyc_access(input int unsigned grade_ns, input int unsigned clk_ps);
    grade_t g = grade_timing(grade_ns);
    return ps_to_cyc(max2(g.t_aa, g.t_oe), clk_ps);
  endfunction

  function automatic int unsigned cyc_off(input int unsigned grade_ns, input int unsigned clk_ps);
    grade_t g = grade_timing(grade_ns);
    return max2(ps_to_cyc(g.t_ohz, clk_ps),
                sat_diff(ps_to_cyc(g.t_rc, clk_ps), cyc_access(grade_ns, clk_ps)));
  endfunction

  function automatic int unsigned cyc_pulse(input int unsigned grade_ns, input int unsigned clk_ps);
    grade_t g = grade_timing(grade_ns);
    return ps_to_cyc(max2(g.t_wp, g.t_dw), clk_ps);
  endfunction

  function automatic int unsigned cyc_recover(input int unsigned grade_ns, input int unsigned clk_ps);
    grade_t g = grade_timing(grade_ns);
    return max2(ps_to_cyc(g.t_wr, clk_ps),
                sat_diff(ps_to_cyc(g.t_wc, clk_ps), cyc_pulse(grade_ns, clk_ps)));
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned N_ACC   = 14,
  parameter int unsigned N_OFF   = 5,
  parameter int unsigned N_WP    = 10,
  parameter int unsigned N_REC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             accept,
  output logic             rd_done,
  output logic             wr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ready,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dout_en
);

  localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(N_ACC - 1);
  localparam logic [CNT_W-1:0] LD_OFF = CNT_W'(N_OFF - 1);
  localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_REC = CNT_W'(N_REC - 1);

  ctl_state_e st_q, st_d;
  logic       rd_gap_done;
  logic       wr_rec_done;

  assign ready       = (st_q == ST_IDLE);
  assign accept      = ready && req_valid;
  assign rd_done     = (st_q == ST_RD) && tmr_zero;
  assign rd_gap_done = (st_q == ST_RD_GAP) && tmr_zero;
  assign wr_done     = (st_q == ST_WR) && tmr_zero;
  assign wr_rec_done = (st_q == ST_WR_REC) && tmr_zero;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      if (req_write) begin
        st_d    = ST_WR;
        tmr_val = LD_WP;
      end else begin
        st_d    = ST_RD;
        tmr_val = LD_ACC;
      end
    end else if (rd_done) begin
      st_d     = ST_RD_GAP;
      tmr_load = 1'b1;
      tmr_val  = LD_OFF;
    end else if (wr_done) begin
      st_d     = ST_WR_REC;
      tmr_load = 1'b1;
      tmr_val  = LD_REC;
    end else if (rd_gap_done || wr_rec_done) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cs_n    = !((st_q == ST_RD) || (st_q == ST_WR));
  assign oe_n    = (st_q != ST_RD);
  assign we_n    = (st_q != ST_WR);
  assign dout_en = (st_q == ST_WR) || (st_q == ST_WR_REC);

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          rd_done,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_din,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  // Address and write data are loaded only at acceptance, while all strobes are high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= mem_din;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned SPEED_NS = 70,
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned AW       = 21,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  localparam int unsigned N_ACC = cyc_access(SPEED_NS, CLK_PS);
  localparam int unsigned N_OFF = cyc_off(SPEED_NS, CLK_PS);
  localparam int unsigned N_WP  = cyc_pulse(SPEED_NS, CLK_PS);
  localparam int unsigned N_REC = cyc_recover(SPEED_NS, CLK_PS);
  localparam int unsigned N_MAX = max2(max2(N_ACC, N_OFF), max2(N_WP, N_REC));
  localparam int unsigned CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  // Named internal events, brought out for the checker.
  logic             accept;
  logic             rd_done;
  logic             wr_done;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctl_fsm #(
    .CNT_W (CNT_W),
    .N_ACC (N_ACC),
    .N_OFF (N_OFF),
    .N_WP  (N_WP),
    .N_REC (N_REC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_zero  (tmr_zero),
    .accept    (accept),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .ready     (req_ready),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dout_en   (mem_dout_en)
  );

  sram_ctl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rd_done   (rd_done),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_din   (mem_din),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dout_en,
  input logic          accept,
  input logic          rd_done
);

  a_r6_addr_stable_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n)) |-> $stable(mem_addr));

  a_r6_addr_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(mem_addr));

  a_r7_driver_only_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n);

  a_r4_write_keeps_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));

  a_r2_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  a_r3_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_valid_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rsp_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !rsp_valid));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_dout_en (mem_dout_en),
  .accept      (accept),
  .rd_done     (rd_done)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

  // Expected cycle counts for the 70 ns grade at a 5 ns clock, rounded up.
  function automatic int cdiv(input int ns);
    return (ns + 4) / 5;
  endfunction
  localparam int E_ACC = (cdiv(70) > cdiv(40)) ? cdiv(70) : cdiv(40);
  localparam int E_OFF = (cdiv(25) > cdiv(70) - E_ACC) ? cdiv(25) : cdiv(70) - E_ACC;
  localparam int E_WP  = (cdiv(50) > cdiv(30)) ? cdiv(50) : cdiv(30);
  localparam int E_REC = (cdiv(5) > cdiv(70) - E_WP) ? cdiv(5) : cdiv(70) - E_WP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [20:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [7:0]  mem_dout;
  logic [7:0]  mem_din = '0;

  int tests = 0;
  int fails = 0;
  logic [7:0] ram [int];

  always #2.5 clk = ~clk;

  sram_ctl dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_dout (mem_dout), .mem_dout_en (mem_dout_en),
    .mem_din (mem_din)
  );

  function automatic logic [7:0] blank(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // RAM model: commits and presents data on falling edges.
  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n) ram[int'(mem_addr)] = mem_dout;
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_din = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : blank(mem_addr);
    else
      mem_din = 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Offer one request at a falling edge; return at the falling edge after E0.
  task automatic offer(input bit wr, input logic [20:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_read(input logic [20:0] a, input logic [7:0] exp);
    int strobe_bad = 0, valid_bad = 0, ready_bad = 0;
    logic [7:0] got = '0;
    offer(1'b0, a, 8'h00);
    for (int i = 0; i <= E_ACC + E_OFF; i++) begin
      if (i > 0) @(negedge clk);
      if ((!mem_cs_n && !mem_oe_n && mem_we_n) != (i < E_ACC)) strobe_bad++;
      if (rsp_valid != (i == E_ACC)) valid_bad++;
      if (rsp_valid) got = rsp_rdata;
      if (req_ready != (i == E_ACC + E_OFF)) ready_bad++;
    end
    chk(strobe_bad == 0, "R2 read strobe window", strobe_bad, 0);
    chk(valid_bad == 0, "R3 one-cycle rsp_valid", valid_bad, 0);
    chk(got == exp, "R3/R9 read data", got, exp);
    chk(ready_bad == 0, "R8 read turnaround", ready_bad, 0);
  endtask

  task automatic t_write(input logic [20:0] a, input logic [7:0] d);
    int we_bad = 0, oe_bad = 0, drv_bad = 0, dat_bad = 0, ready_bad = 0, addr_bad = 0;
    offer(1'b1, a, d);
    for (int i = 0; i <= E_WP + E_REC; i++) begin
      if (i > 0) @(negedge clk);
      if ((!mem_cs_n && !mem_we_n) != (i < E_WP)) we_bad++;
      if (!mem_oe_n) oe_bad++;
      if (mem_dout_en != (i < E_WP + E_REC)) drv_bad++;
      if (i < E_WP && mem_dout != d) dat_bad++;
      if (mem_addr != a) addr_bad++;
      if (req_ready != (i == E_WP + E_REC)) ready_bad++;
    end
    chk(we_bad == 0, "R4 write pulse window", we_bad, 0);
    chk(oe_bad == 0 && dat_bad == 0, "R4 oe high and data", oe_bad + dat_bad, 0);
    chk(drv_bad == 0, "R7 driver window", drv_bad, 0);
    chk(addr_bad == 0, "R6 address held", addr_bad, 0);
    chk(ready_bad == 0, "R5 write cycle length", ready_bad, 0);
  endtask

  // A write offered while a read is busy must not reach the RAM.
  task automatic t_busy_ignore(input logic [20:0] a, input logic [20:0] x);
    int addr_bad = 0, we_bad = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = x; req_wdata = 8'hEE;
    for (int i = 1; i < E_ACC + E_OFF; i++) begin
      @(negedge clk);
      if (mem_addr != a) addr_bad++;
      if (!mem_we_n) we_bad++;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(addr_bad == 0 && we_bad == 0, "R8 busy request ignored", addr_bad + we_bad, 0);
    t_read(x, blank(x));
  endtask

  task automatic t_reset;
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high",
        {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dout_en && req_ready && !rsp_valid, "R1 idle outputs",
        {mem_dout_en, req_ready, rsp_valid}, 3'b010);
    chk(req_ready && mem_cs_n && !rsp_valid, "R10 idle quiet", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(21'h000123, blank(21'h000123));
    t_write(21'h000000, 8'hA5);
    t_write(21'h1FFFFF, 8'h3C);
    t_write(21'h0ABCDE, 8'hFF);
    t_read(21'h000000, 8'hA5);
    t_read(21'h1FFFFF, 8'h3C);
    t_read(21'h0ABCDE, 8'hFF);
    t_write(21'h0ABCDE, 8'h00);
    t_read(21'h0ABCDE, 8'h00);
    t_read(21'h000000, 8'hA5);
    t_busy_ignore(21'h1FFFFF, 21'h012345);
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule